// File: doc/BRIEF.md
# Fetch Group Aligner

The aligner sits between the instruction cache and the decoders. Each transfer gives it one cache line of instruction slots and the fetch PC. It rotates the line so that the slot addressed by the PC lands in decoder lane 0, and the following slots land in lanes 1 to N-1 in program order. The PC counts in slots, and only its low log2(LINE_SLOTS) bits select the starting slot.

The line holds more slots than the group has lanes. A misaligned PC therefore still gives a full group of N instructions, provided at least N slots remain before the end of the line. Closer to the end, the group is cut short at the line boundary. The lanes past that point are marked invalid, and their data is forced to zero rather than wrapping around to the start of the line.

The block also returns the PC of the next fetch, which is the current PC plus the number of valid lanes. A truncated group therefore points the next fetch at the start of the next line. The result is held in a single output register with a valid/ready handshake on both sides.

Top module: `fetch_aligner`

## Requirements
- R1: While rst_ni is low, and after its release until the first transfer, out_valid_o is 0 and lane_valid_o is all zero.
- R2: For a group with c valid lanes and start slot s = pc_i mod LINE_SLOTS, lane k (k < c) carries slot s+k of line_i. Slot j occupies line_i bits [j*INSTR_W +: INSTR_W], and lane k occupies lane_data_o bits [k*INSTR_W +: INSTR_W]. PC bits above the start-slot field have no effect on lane selection.
- R3: When s <= LINE_SLOTS-GROUP_N, all GROUP_N lanes are valid (lane_valid_o all ones).
- R4: When s > LINE_SLOTS-GROUP_N, exactly LINE_SLOTS-s lanes are valid. The remaining lanes are invalid and carry zero data; slots from the start of the line are never wrapped into them.
- R5: lane_valid_o is always a contiguous run of ones starting at lane 0 (bit k is lane k). Whenever out_valid_o is 1, lane 0 is valid.
- R6: next_pc_o equals the accepted pc_i plus the number of valid lanes, modulo 2^PC_W.
- R7: in_ready_o is 1 when the output register is empty or out_ready_i is 1. A transfer with in_valid_i and in_ready_o both high at a clock edge appears on the outputs, with out_valid_o high, in the following cycle.
- R8: While out_valid_o is 1 and out_ready_i is 0, all outputs hold their values and in_ready_o is 0, so no new input is taken.
- R9: When the held group is consumed (out_ready_i high) and no new transfer arrives, out_valid_o falls and lane_valid_o becomes all zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Line and PC are offered |
| in_ready_o | output | 1 | Aligner can take a line this cycle |
| line_i | input | LINE_SLOTS*INSTR_W | Cache line, slot 0 in the low bits |
| pc_i | input | PC_W | Fetch PC in slot units |
| out_valid_o | output | 1 | An aligned group is held |
| out_ready_i | input | 1 | Decoders take the held group |
| lane_data_o | output | GROUP_N*INSTR_W | Aligned lanes, lane 0 in the low bits |
| lane_valid_o | output | GROUP_N | Per-lane valid mask |
| next_pc_o | output | PC_W | PC of the next fetch |

## Verification
The bench concentrates on start slots around the truncation point: the last slot that still gives a full group (s = LINE_SLOTS-GROUP_N), the first slot that truncates, and the final slot of the line. A rotator that wraps would show slot 0 data in the upper lanes at those points, and an off-by-one in the lane count would show as a wrong mask or a next PC that misses the line boundary. A PC whose low bits are 01001 is applied with non-zero upper bits, which exposes any use of the upper bits in slot selection. Stalls with a second line waiting catch an output register that drops or overwrites its contents, and idle cycles after a drain catch a mask left set while nothing is valid.

// File: rtl/fetch_aligner_pkg.sv
package fetch_aligner_pkg;
  localparam int unsigned DEF_LINE_SLOTS = 8;
  localparam int unsigned DEF_GROUP_N    = 4;
  localparam int unsigned DEF_INSTR_W    = 32;
  localparam int unsigned DEF_PC_W       = 32;
endpackage

// File: rtl/fetch_aligner_rotator.sv
module fetch_aligner_rotator #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned W     = 32,
  localparam int unsigned OFS_W = $clog2(SLOTS)
) (
  input  logic [SLOTS*W-1:0] line_i,
  input  logic [OFS_W-1:0]   shift_i,
  output logic [SLOTS*W-1:0] rot_o
);
  logic [SLOTS*W-1:0] stage [OFS_W+1];

  assign stage[0] = line_i;

  // log-depth barrel: stage s moves slots down by 2^s when its shift bit is set
  for (genvar s = 0; s < OFS_W; s++) begin : g_stage
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      localparam int unsigned SRC = (j + (1 << s)) % SLOTS;
      assign stage[s+1][j*W +: W] = shift_i[s] ? stage[s][SRC*W +: W]
                                               : stage[s][j*W +: W];
    end
  end

  assign rot_o = stage[OFS_W];
endmodule

// File: rtl/fetch_aligner_mask.sv
module fetch_aligner_mask #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned N     = 4,
  localparam int unsigned OFS_W = $clog2(SLOTS),
  localparam int unsigned CNT_W = $clog2(N+1)
) (
  input  logic [OFS_W-1:0] ofs_i,
  output logic [N-1:0]     lane_valid_o,
  output logic [CNT_W-1:0] count_o
);
  logic [OFS_W:0] avail;

  always_comb begin
    avail = (OFS_W+1)'(SLOTS) - {1'b0, ofs_i};
    if (avail >= (OFS_W+1)'(N)) count_o = CNT_W'(N);
    else                        count_o = CNT_W'(avail);
    for (int k = 0; k < N; k++) begin
      lane_valid_o[k] = (k < int'(count_o));
    end
  end
endmodule

// File: rtl/fetch_aligner_out_reg.sv
module fetch_aligner_out_reg #(
  parameter int unsigned DW   = 128,
  parameter int unsigned N    = 4,
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [DW-1:0]   data_i,
  input  logic [N-1:0]    mask_i,
  input  logic [PC_W-1:0] npc_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [DW-1:0]   data_o,
  output logic [N-1:0]    mask_o,
  output logic [PC_W-1:0] npc_o
);
  logic load;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign load       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      mask_o      <= '0;
      npc_o       <= '0;
    end else if (load) begin
      out_valid_o <= 1'b1;
      data_o      <= data_i;
      mask_o      <= mask_i;
      npc_o       <= npc_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
      mask_o      <= '0;
    end
  end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int unsigned LINE_SLOTS = fetch_aligner_pkg::DEF_LINE_SLOTS,
  parameter int unsigned GROUP_N    = fetch_aligner_pkg::DEF_GROUP_N,
  parameter int unsigned INSTR_W    = fetch_aligner_pkg::DEF_INSTR_W,
  parameter int unsigned PC_W       = fetch_aligner_pkg::DEF_PC_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [LINE_SLOTS*INSTR_W-1:0] line_i,
  input  logic [PC_W-1:0]               pc_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [GROUP_N*INSTR_W-1:0]    lane_data_o,
  output logic [GROUP_N-1:0]            lane_valid_o,
  output logic [PC_W-1:0]               next_pc_o
);
  localparam int unsigned OFS_W = $clog2(LINE_SLOTS);
  localparam int unsigned CNT_W = $clog2(GROUP_N+1);
  localparam int unsigned GDW   = GROUP_N*INSTR_W;

  initial begin
    if ((1 << OFS_W) != LINE_SLOTS || LINE_SLOTS < 2 || GROUP_N > LINE_SLOTS || GROUP_N < 1)
      $error("fetch_aligner: bad geometry");
  end

  logic [OFS_W-1:0]              ofs;
  logic [LINE_SLOTS*INSTR_W-1:0] rot;
  logic [GROUP_N-1:0]            mask;
  logic [CNT_W-1:0]              cnt;
  logic [GDW-1:0]                lanes;
  logic [PC_W-1:0]               npc;

  assign ofs = pc_i[OFS_W-1:0];

  fetch_aligner_rotator #(.SLOTS(LINE_SLOTS), .W(INSTR_W)) u_rot (
    .line_i (line_i),
    .shift_i(ofs),
    .rot_o  (rot)
  );

  fetch_aligner_mask #(.SLOTS(LINE_SLOTS), .N(GROUP_N)) u_mask (
    .ofs_i       (ofs),
    .lane_valid_o(mask),
    .count_o     (cnt)
  );

  // lanes past the line end carry zero, never wrapped slots
  for (genvar k = 0; k < GROUP_N; k++) begin : g_lane
    assign lanes[k*INSTR_W +: INSTR_W] = mask[k] ? rot[k*INSTR_W +: INSTR_W] : '0;
  end

  assign npc = pc_i + PC_W'(cnt);

  fetch_aligner_out_reg #(.DW(GDW), .N(GROUP_N), .PC_W(PC_W)) u_oreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .data_i     (lanes),
    .mask_i     (mask),
    .npc_i      (npc),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .data_o     (lane_data_o),
    .mask_o     (lane_valid_o),
    .npc_o      (next_pc_o)
  );
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
  parameter int unsigned LINE_SLOTS = 8,
  parameter int unsigned GROUP_N    = 4,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned PC_W       = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          in_valid_i,
  input logic                          in_ready_o,
  input logic [LINE_SLOTS*INSTR_W-1:0] line_i,
  input logic [PC_W-1:0]               pc_i,
  input logic                          out_valid_o,
  input logic                          out_ready_i,
  input logic [GROUP_N*INSTR_W-1:0]    lane_data_o,
  input logic [GROUP_N-1:0]            lane_valid_o,
  input logic [PC_W-1:0]               next_pc_o
);
  localparam int unsigned OFS_W = $clog2(LINE_SLOTS);

  logic accept;
  logic full_start;
  assign accept     = in_valid_i & in_ready_o;
  assign full_start = int'(pc_i[OFS_W-1:0]) <= int'(LINE_SLOTS - GROUP_N);

  AST_RESET_EMPTY: assert property (@(posedge clk_i) !rst_ni |-> (!out_valid_o && lane_valid_o == '0)); // R1

  AST_FULL_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && full_start) |=> (lane_valid_o == '1)); // R3

  AST_MASK_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_valid_o & (lane_valid_o + 1'b1)) == '0)); // R5

  AST_LANE0_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> lane_valid_o[0]); // R5

  AST_NEXT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (next_pc_o == $past(pc_i) + PC_W'($countones(lane_valid_o)))); // R6

  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(lane_data_o)
      && $stable(lane_valid_o) && $stable(next_pc_o))); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o); // R8

  AST_IDLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (lane_valid_o == '0)); // R9
endmodule

bind fetch_aligner fetch_aligner_chk #(
  .LINE_SLOTS(LINE_SLOTS), .GROUP_N(GROUP_N), .INSTR_W(INSTR_W), .PC_W(PC_W)
) u_chk (.*);

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
  localparam int unsigned S  = fetch_aligner_pkg::DEF_LINE_SLOTS;
  localparam int unsigned N  = fetch_aligner_pkg::DEF_GROUP_N;
  localparam int unsigned W  = fetch_aligner_pkg::DEF_INSTR_W;
  localparam int unsigned PW = fetch_aligner_pkg::DEF_PC_W;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [S*W-1:0]  line = '0;
  logic [PW-1:0]   pc = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [N*W-1:0]  lane_data;
  logic [N-1:0]    lane_valid;
  logic [PW-1:0]   next_pc;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fetch_aligner uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .line_i(line), .pc_i(pc), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .lane_data_o(lane_data), .lane_valid_o(lane_valid), .next_pc_o(next_pc)
  );

  function automatic int exp_cnt(logic [PW-1:0] p);
    int avail = int'(S) - int'(p % S);
    return (avail < int'(N)) ? avail : int'(N);
  endfunction

  function automatic logic [N-1:0] exp_mask(logic [PW-1:0] p);
    logic [N-1:0] m = '0;
    for (int k = 0; k < int'(N); k++) if (k < exp_cnt(p)) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [N*W-1:0] exp_data(logic [PW-1:0] p, logic [S*W-1:0] l);
    logic [N*W-1:0] d = '0;
    int s = int'(p % S);
    for (int k = 0; k < int'(N); k++)
      if (k < exp_cnt(p)) d[k*W +: W] = l[(s+k)*W +: W];
    return d;
  endfunction

  function automatic logic [S*W-1:0] rand_line();
    logic [S*W-1:0] l;
    for (int j = 0; j < int'(S); j++) l[j*W +: W] = $urandom;
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N*W-1:0] act,
                     input logic [N*W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic chk_group(input string tag, input logic [PW-1:0] p, input logic [S*W-1:0] l);
    chk(out_valid == 1'b1, {tag, " R7 out_valid"}, N*W'(out_valid), 1);
    chk(lane_valid == exp_mask(p), {tag, " R3/R4 mask"}, N*W'(lane_valid), N*W'(exp_mask(p)));
    chk(lane_data == exp_data(p, l), {tag, " R2 data"}, lane_data, exp_data(p, l));
    chk(next_pc == p + PW'(exp_cnt(p)), {tag, " R6 next_pc"}, N*W'(next_pc),
        N*W'(p + PW'(exp_cnt(p))));
  endtask

  task automatic chk_idle(input string tag);
    chk(out_valid == 1'b0, {tag, " R9 out_valid"}, N*W'(out_valid), 0);
    chk(lane_valid == '0, {tag, " R9 mask"}, N*W'(lane_valid), 0);
  endtask

  // one transfer, then drain with one idle cycle
  task automatic send_one(input string tag, input logic [PW-1:0] p, input logic [S*W-1:0] l);
    @(negedge clk);
    in_valid = 1'b1; pc = p; line = l; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_group(tag, p, l);
    @(negedge clk);
    chk_idle(tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4*150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [S*W-1:0] la, lb;
    logic [PW-1:0]  pa, pb;
    logic [PW-1:0]  prev_pc;
    logic [S*W-1:0] prev_line;
    bit             prev_go;
    void'($urandom(32'd20240611));

    #7;
    chk_idle("R1 in reset");
    chk(out_valid == 1'b0, "R1 reset valid", N*W'(out_valid), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && lane_valid == '0, "R1 after release", N*W'(lane_valid), 0);
    chk(in_ready == 1'b1, "R7 ready when empty", N*W'(in_ready), 1);

    // directed corner cases
    send_one("aligned", 32'h0000_2000, rand_line());
    send_one("ofs01001 upper bits R2", 32'hABCD_1009, rand_line());
    send_one("last full start R3", 32'h0000_0104, rand_line());
    send_one("first truncating R4", 32'h0000_0105, rand_line());
    send_one("last slot R4", 32'h0000_0107, rand_line());
    send_one("pc wrap R6", 32'hFFFF_FFFE, rand_line());

    // stall with a second line waiting
    la = rand_line(); lb = rand_line(); pa = 32'h0000_0306; pb = 32'h0000_0402;
    @(negedge clk);
    in_valid = 1'b1; pc = pa; line = la; out_ready = 1'b0;
    @(negedge clk);
    chk_group("stall load", pa, la);
    pc = pb; line = lb;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_group("R8 stall hold", pa, la);
      chk(in_ready == 1'b0, "R8 ready low", N*W'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_group("R7 after stall", pb, lb);
    @(negedge clk);
    chk_idle("R9 drain");

    // random streaming with gaps and occasional stalls
    prev_go = 1'b0; prev_pc = '0; prev_line = '0;
    for (int it = 0; it < 400; it++) begin
      bit go;
      @(negedge clk);
      if (prev_go) chk_group("R2 random", prev_pc, prev_line);
      else         chk_idle("R9 random gap");
      if (($urandom % 8) == 0) begin
        out_ready = 1'b0;
        in_valid  = 1'b1;
        @(negedge clk);
        if (prev_go) chk_group("R8 random stall", prev_pc, prev_line);
        out_ready = 1'b1;
      end
      go = ($urandom % 4) != 0;
      if (go) begin
        pc   = $urandom;
        if (($urandom % 2) == 0) pc[$clog2(S)-1:0] = $clog2(S)'(S - 1 - ($urandom % N));
        line = rand_line();
        in_valid = 1'b1;
        prev_pc = pc; prev_line = line;
      end else begin
        in_valid = 1'b0;
      end
      prev_go = go;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (prev_go) chk_group("R2 random tail", prev_pc, prev_line);
    @(negedge clk);
    chk_idle("R9 final");
    finish_run();
  end
endmodule